// File: doc/BRIEF.md
# Pad Input Debounce Filter

This block cleans up a slow, already synchronized pad input before it enters the chip's input path. A configuration write selects a debounce time of 2^N base periods of 31.25 us, with N between 3 and 15. A free-running prescaler turns the system clock into the 31.25 us base tick. When filtering is engaged, the output level moves to a new input value only after that value has been held without interruption for 2^N base ticks. When filtering is off, the input passes straight through with one register stage.

Filtering is engaged by two stored bits that software always sets or clears together: the enable flag in the debounce setting register and a filter-route select bit kept beside it. A write that asks for a period shorter than 2^3 ticks is refused and leaves all state as it was. A write that turns debounce off clears the enable flag, the exponent and the route select. The block also reports the programmed period in ticks, which reads zero while debounce is off.

Top module: `pad_debounce`

## Requirements
- R1: After reset, `dbnSetting` is 0, `routeSel` is 0, `periodTicks` is 0 and `padOut` is 0.
- R2: A write with `cfgEnable`=1 and `cfgExp` from 3 to 15 stores `dbnSetting` with bit 0 = 1 (enable) and bits 4:1 = `cfgExp` (exponent), and sets `routeSel` to 1, visible the cycle after the write.
- R3: A write with `cfgEnable`=1 and `cfgExp` below 3 is refused: `dbnSetting`, `routeSel` and `periodTicks` keep their values.
- R4: A write with `cfgEnable`=0 clears `dbnSetting` to 0 and `routeSel` to 0, whatever `cfgExp` holds.
- R5: `periodTicks` equals 2^N while the enable bit is set and 0 while it is clear.
- R6: `baseTick` is high for one clock in every `CLKS_PER_TICK` clocks.
- R7: With filtering engaged, `padOut` takes a new input value only after the input has differed from `padOut` for 2^N consecutive base ticks; with fewer ticks it does not move, and it changes only in a cycle where `baseTick` is high.
- R8: With filtering engaged, an input that returns to the `padOut` level before 2^N ticks restarts the count from zero.
- R9: An accepted configuration write while a count is in progress restarts the count from zero.
- R10: With debounce off, `padOut` equals `padIn` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| padIn | input | 1 | Synchronized pad level |
| cfgWe | input | 1 | Configuration write strobe |
| cfgEnable | input | 1 | Requested enable for the write |
| cfgExp | input | EXP_W | Requested exponent N for the write |
| dbnSetting | output | EXP_W+1 | Stored setting: bit 0 enable, bits 4:1 exponent |
| routeSel | output | 1 | Filter-route select bit |
| periodTicks | output | 2**EXP_W | Programmed period in base ticks, 0 when off |
| baseTick | output | 1 | 31.25 us time-base pulse |
| padOut | output | 1 | Filtered pad level |

## Verification
A tick counter that runs past its target or is not cleared on an input reversal shows at `padOut` as an edge that arrives earlier or later than 2^N ticks after the last input change, within one debounce period. A setting register that takes a refused write shows on `dbnSetting` and `periodTicks` in the very next cycle. A bypass decision that is wrong shows as `padOut` lagging `padIn` by a full period when debounce is off, or following it in one clock when it is on.

// File: rtl/pad_debounce_pkg.sv
package pad_debounce_pkg;

  // Strobes handed from the control side to the filter datapath.
  typedef struct packed {
    logic       tick;     // one base period elapsed
    logic       restart;  // accepted configuration write this cycle
    logic       bypass;   // filtering not engaged
    logic [3:0] expSel;   // current exponent N
  } dbnStrobes_t;

endpackage

// File: rtl/pad_debounce_ctrl.sv
module pad_debounce_ctrl
  import pad_debounce_pkg::*;
#(
  parameter int EXP_W         = 4,
  parameter int MIN_EXP       = 3,
  parameter int CLKS_PER_TICK = 1562
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic               cfgEnable,
  input  logic [EXP_W-1:0]   cfgExp,
  output logic [EXP_W:0]     dbnSetting,
  output logic               routeSel,
  output logic [(2**EXP_W)-1:0] periodTicks,
  output dbnStrobes_t        strobes
);
  localparam int CNT_W = 2 ** EXP_W;
  localparam int PRE_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_TICK - 1);

  logic             enReg;
  logic [EXP_W-1:0] expReg;
  logic             selReg;
  logic [PRE_W-1:0] preCnt;
  logic             tickNow;
  logic             accept;

  // A write that disables is always taken; an enabling write needs a legal N.
  assign accept = cfgWe && (!cfgEnable || (cfgExp >= EXP_W'(MIN_EXP)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg  <= 1'b0;
      expReg <= '0;
      selReg <= 1'b0;
    end else if (accept) begin
      if (cfgEnable) begin
        enReg  <= 1'b1;
        expReg <= cfgExp;
        selReg <= 1'b1;
      end else begin
        enReg  <= 1'b0;
        expReg <= '0;
        selReg <= 1'b0;
      end
    end
  end

  // Base time prescaler.
  assign tickNow = (preCnt == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preCnt <= '0;
    else if (tickNow) preCnt <= '0;
    else              preCnt <= preCnt + 1'b1;
  end

  assign dbnSetting  = {expReg, enReg};
  assign routeSel    = selReg;
  assign periodTicks = enReg ? (CNT_W'(1) << expReg) : '0;

  always_comb begin
    strobes         = '0;
    strobes.tick    = tickNow;
    strobes.restart = accept;
    strobes.bypass  = !(enReg && selReg);
    strobes.expSel  = 4'(expReg);
  end

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgEnable && (cfgExp < EXP_W'(MIN_EXP))) |=> $stable(dbnSetting) && $stable(routeSel)); // R3
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !cfgEnable) |=> (dbnSetting == '0) && !routeSel); // R4
  AST_EXP_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    dbnSetting[0] |-> (dbnSetting[EXP_W:1] >= EXP_W'(MIN_EXP))); // R2
  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgEnable && (cfgExp >= EXP_W'(MIN_EXP))) |=> routeSel && dbnSetting[0]); // R2

endmodule

// File: rtl/pad_debounce_filter.sv
module pad_debounce_filter
  import pad_debounce_pkg::*;
#(
  parameter int EXP_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        padIn,
  input  dbnStrobes_t strobes,
  output logic        padOut
);
  localparam int CNT_W = 2 ** EXP_W;

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] nextCnt;
  logic             differs;

  assign target  = CNT_W'(1) << strobes.expSel[EXP_W-1:0];
  assign nextCnt = tickCnt + 1'b1;
  assign differs = (padIn != padOut);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      padOut  <= 1'b0;
      tickCnt <= '0;
    end else if (strobes.bypass) begin
      padOut  <= padIn;
      tickCnt <= '0;
    end else if (strobes.restart || !differs) begin
      tickCnt <= '0;
    end else if (strobes.tick) begin
      if (nextCnt == target) begin
        padOut  <= padIn;
        tickCnt <= '0;
      end else begin
        tickCnt <= nextCnt;
      end
    end
  end

  AST_NO_EARLY_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.bypass && !strobes.tick) |=> $stable(padOut)); // R7
  AST_REVERSAL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.bypass && !differs) |=> (tickCnt == '0)); // R8
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> (tickCnt == '0)); // R9
  AST_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bypass |=> (padOut == $past(padIn))); // R10

endmodule

// File: rtl/pad_debounce.sv
module pad_debounce
  import pad_debounce_pkg::*;
#(
  parameter int EXP_W         = 4,
  parameter int MIN_EXP       = 3,
  parameter int CLKS_PER_TICK = 1562
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  padIn,
  input  logic                  cfgWe,
  input  logic                  cfgEnable,
  input  logic [EXP_W-1:0]      cfgExp,
  output logic [EXP_W:0]        dbnSetting,
  output logic                  routeSel,
  output logic [(2**EXP_W)-1:0] periodTicks,
  output logic                  baseTick,
  output logic                  padOut
);
  dbnStrobes_t strobes;

  pad_debounce_ctrl #(
    .EXP_W(EXP_W), .MIN_EXP(MIN_EXP), .CLKS_PER_TICK(CLKS_PER_TICK)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgEnable(cfgEnable),
    .cfgExp(cfgExp), .dbnSetting(dbnSetting), .routeSel(routeSel),
    .periodTicks(periodTicks), .strobes(strobes)
  );

  pad_debounce_filter #(.EXP_W(EXP_W)) filt_i (
    .clk(clk), .rstN(rstN), .padIn(padIn), .strobes(strobes), .padOut(padOut)
  );

  assign baseTick = strobes.tick;

endmodule

// File: tb/pad_debounce_tb_top.sv
`timescale 1ns/1ps
module pad_debounce_tb_top;
  localparam int EXP_W = 4;
  localparam int P     = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic padIn = 1'b0;
  logic cfgWe = 1'b0;
  logic cfgEnable = 1'b0;
  logic [3:0] cfgExp = '0;
  logic [4:0] dbnSetting;
  logic routeSel;
  logic [15:0] periodTicks;
  logic baseTick;
  logic padOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  pad_debounce #(.EXP_W(EXP_W), .MIN_EXP(3), .CLKS_PER_TICK(P)) dut_i (
    .clk(clk), .rstN(rstN), .padIn(padIn), .cfgWe(cfgWe), .cfgEnable(cfgEnable),
    .cfgExp(cfgExp), .dbnSetting(dbnSetting), .routeSel(routeSel),
    .periodTicks(periodTicks), .baseTick(baseTick), .padOut(padOut)
  );

  // {en, exp, expected setting, expected routeSel, expected periodTicks}
  localparam int NV = 8;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 4'd3,  5'b00111, 1'b1, 16'd8},
    {1'b1, 4'd15, 5'b11111, 1'b1, 16'd32768},
    {1'b1, 4'd2,  5'b11111, 1'b1, 16'd32768},
    {1'b0, 4'd9,  5'b00000, 1'b0, 16'd0},
    {1'b1, 4'd0,  5'b00000, 1'b0, 16'd0},
    {1'b1, 4'd7,  5'b01111, 1'b1, 16'd128},
    {1'b1, 4'd1,  5'b01111, 1'b1, 16'd128},
    {1'b0, 4'd0,  5'b00000, 1'b0, 16'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input logic en, input logic [3:0] n);
    cfgWe = 1'b1; cfgEnable = en; cfgExp = n;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic waitClks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 setting", 32'(dbnSetting), 0);
    check("R1 routeSel", 32'(routeSel), 0);
    check("R1 periodTicks", 32'(periodTicks), 0);
    check("R1 padOut", 32'(padOut), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 / R3 / R4 / R5 vector table
    for (int i = 0; i < NV; i++) begin
      writeCfg(VEC[i][26], VEC[i][25:22]);
      check($sformatf("R2/R3/R4 setting vec %0d", i), 32'(dbnSetting), 32'(VEC[i][21:17]));
      check($sformatf("R2/R4 routeSel vec %0d", i), 32'(routeSel), 32'(VEC[i][16]));
      check($sformatf("R5 periodTicks vec %0d", i), 32'(periodTicks), 32'(VEC[i][15:0]));
    end

    // R6: tick spacing
    while (baseTick !== 1'b1) @(negedge clk);
    begin
      int gap = 0;
      do begin @(negedge clk); gap++; end while (baseTick !== 1'b1 && gap < 50);
      check("R6 tick spacing", gap, P);
    end

    // R10: bypass follows in one clock
    padIn = 1'b1; @(negedge clk);
    check("R10 bypass rise", 32'(padOut), 1);
    padIn = 1'b0; @(negedge clk);
    check("R10 bypass fall", 32'(padOut), 0);
    padIn = 1'b1; @(negedge clk);

    // R7: N=3 (8 ticks = 32 clocks)
    writeCfg(1'b1, 4'd3);
    check("R7 level before", 32'(padOut), 1);
    padIn = 1'b0; waitClks(24);
    check("R7 held 6 ticks", 32'(padOut), 1);
    waitClks(16);
    check("R7 held >=9 ticks", 32'(padOut), 0);

    // R8: reversal restarts
    padIn = 1'b1; waitClks(24);
    padIn = 1'b0; waitClks(8);
    padIn = 1'b1; waitClks(24);
    check("R8 after reversal", 32'(padOut), 0);
    waitClks(20);
    check("R8 full period", 32'(padOut), 1);

    // R9: accepted write while counting restarts
    padIn = 1'b0; waitClks(24);
    writeCfg(1'b1, 4'd3);
    waitClks(23);
    check("R9 restarted count", 32'(padOut), 1);
    waitClks(20);
    check("R9 after full period", 32'(padOut), 0);

    // R7 with N=5 (32 ticks = 128 clocks)
    writeCfg(1'b1, 4'd5);
    padIn = 1'b1; waitClks(120);
    check("R7 N=5 held 30 ticks", 32'(padOut), 0);
    waitClks(16);
    check("R7 N=5 held >=33 ticks", 32'(padOut), 1);

    // R4 / R10: disabling restores bypass
    writeCfg(1'b0, 4'd5);
    padIn = 1'b0; @(negedge clk);
    check("R10 bypass after disable", 32'(padOut), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule